// File: doc/BRIEF.md
# Single-Bit Boolean Operation Unit

This unit carries out the single-bit instructions of a small 8-bit controller core. Each operation gives an absolute 8-bit bit address and a 4-bit operation code. The unit turns the bit address into a byte address and a bit index, and it presents the byte address on a read port. The byte storage is outside the block and returns the byte in the same cycle. The unit then either rewrites the byte with only the addressed bit changed, or uses the bit to update a carry flag that acts as a one-bit accumulator, or tests the bit for a conditional jump. Adding the jump offset to the program counter is left to the core. The unit only reports whether the jump is taken.

The unit owns the carry flag. Bit address 0xD7 is the top bit of the status byte at 0xD0, and it refers to that same flag. An operation can be issued on every cycle. If one operation rewrites a byte that the next operation reads, the unit forwards the pending write, so the external store is never read stale.

Top module: `boolbit_unit`

## Requirements
- R1: A bit address below 0x80 selects byte 0x20 + addr[6:3], bit addr[2:0]. rdAddr shows this byte in the same cycle as opValid.
- R2: A bit address of 0x80 or more selects byte {addr[7:3], 000}, bit addr[2:0]. The selected byte is always a multiple of 8 in the range 0x80 to 0xF8.
- R3: Codes 1 (set), 2 (clear) and 3 (complement) write the selected byte back one cycle later. Only the addressed bit changes. The other seven bits are kept.
- R4: Code 4 copies the bit into carry. Code 5 writes carry into the bit with the same byte rewrite as R3.
- R5: Codes 6/7 OR, 8/9 AND and 10/11 XOR into carry. The even code uses the bit and the odd code uses its complement. None of these codes writes the byte.
- R6: Code 12 reports the jump as taken when the bit is 1. Code 13 reports it as taken when the bit is 0. Neither code writes the byte. jumpValid marks the result.
- R7: Code 14 takes the jump when the bit is 1, and in that case it also writes the byte back with the bit cleared. When the bit is 0 it does not jump and does not write.
- R8: Bit address 0xD7 reads and writes the carry flag. Any write to that bit updates carry, and the byte written to 0xD0 holds the new carry in bit 7.
- R9: When an operation reads the byte written by the operation just before it, the unit uses the newly written value.
- R10: After reset, carry is 0 and wrEn and jumpValid are low. A cycle without opValid, or with code 0 or 15, writes nothing, reports no jump and keeps carry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 4 | Operation code (see requirements) |
| bitAddr | input | 8 | Absolute bit address |
| rdAddr | output | 8 | Byte address to read |
| rdData | input | 8 | Byte read from rdAddr, same cycle |
| wrEn | output | 1 | Byte write strobe |
| wrAddr | output | 8 | Byte address to write |
| wrData | output | 8 | New byte value |
| carry | output | 1 | Carry flag |
| jumpValid | output | 1 | A bit-test jump result is present |
| jumpTaken | output | 1 | The jump condition holds |

## Verification
rdAddr depends only on the inputs, so the bench checks it one time unit after driving an operation. The write strobe, address and data, the carry and both jump outputs are registered once. The bench samples them at the falling edge after the rising edge that captures the operation. Operations are issued back to back without gaps, so each one reads a byte that the previous operation may have just rewritten, and the forwarding path is checked on every pair. Idle cycles are placed between address groups to confirm that a cycle without an operation changes no output.

// File: rtl/boolbit_pkg.sv
package boolbit_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(BYTE_W);

  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_SET     = 4'd1,
    OP_CLEAR   = 4'd2,
    OP_TOGGLE  = 4'd3,
    OP_LOADC   = 4'd4,
    OP_STOREC  = 4'd5,
    OP_ORC     = 4'd6,
    OP_ORNC    = 4'd7,
    OP_ANDC    = 4'd8,
    OP_ANDNC   = 4'd9,
    OP_XORC    = 4'd10,
    OP_XORNC   = 4'd11,
    OP_JSET    = 4'd12,
    OP_JCLR    = 4'd13,
    OP_JSETCLR = 4'd14,
    OP_RSVD    = 4'd15
  } bitOp_e;

  typedef enum logic [1:0] {
    NB_ONE,
    NB_ZERO,
    NB_INV,
    NB_CARRY
  } newBit_e;

  typedef enum logic [1:0] {
    CF_LOAD,
    CF_OR,
    CF_AND,
    CF_XOR
  } carryFn_e;

  typedef struct packed {
    logic     writeBit;
    logic     writeIfSet;
    newBit_e  newBitSel;
    logic     carryUpd;
    carryFn_e carryFn;
    logic     invertBit;
    logic     jump;
    logic     jumpOnSet;
  } strobes_t;
endpackage

// File: rtl/boolbit_addrmap.sv
module boolbit_addrmap
  import boolbit_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RAM_BASE   = 8'h20,
  parameter logic [BYTE_W-1:0] CARRY_ADDR = 8'hD7
) (
  input  logic [BYTE_W-1:0] bitAddr,
  output logic [BYTE_W-1:0] byteAddr,
  output logic [IDX_W-1:0]  bitIdx,
  output logic              isCarry
);
  localparam int ROW_W = BYTE_W - IDX_W;

  logic [ROW_W-1:0]  row;
  logic [BYTE_W-1:0] lowByte;
  logic [BYTE_W-1:0] highByte;

  assign row      = bitAddr[BYTE_W-1:IDX_W];
  assign lowByte  = RAM_BASE + BYTE_W'({1'b0, row[ROW_W-2:0]});
  assign highByte = {row, {IDX_W{1'b0}}};

  always_comb begin
    if (bitAddr[BYTE_W-1]) byteAddr = highByte;
    else                   byteAddr = lowByte;
  end

  assign bitIdx  = bitAddr[IDX_W-1:0];
  assign isCarry = (bitAddr == CARRY_ADDR);
endmodule

// File: rtl/boolbit_ctrl.sv
module boolbit_ctrl
  import boolbit_pkg::*;
(
  input  logic [3:0] opCode,
  output strobes_t   stb
);
  bitOp_e op;
  assign op = bitOp_e'(opCode);

  always_comb begin
    stb = '0;
    stb.newBitSel = NB_ONE;
    stb.carryFn   = CF_LOAD;
    unique case (op)
      OP_SET:     begin stb.writeBit = 1'b1; stb.newBitSel = NB_ONE;   end
      OP_CLEAR:   begin stb.writeBit = 1'b1; stb.newBitSel = NB_ZERO;  end
      OP_TOGGLE:  begin stb.writeBit = 1'b1; stb.newBitSel = NB_INV;   end
      OP_STOREC:  begin stb.writeBit = 1'b1; stb.newBitSel = NB_CARRY; end
      OP_LOADC:   begin stb.carryUpd = 1'b1; stb.carryFn = CF_LOAD; end
      OP_ORC:     begin stb.carryUpd = 1'b1; stb.carryFn = CF_OR;  end
      OP_ORNC:    begin stb.carryUpd = 1'b1; stb.carryFn = CF_OR;  stb.invertBit = 1'b1; end
      OP_ANDC:    begin stb.carryUpd = 1'b1; stb.carryFn = CF_AND; end
      OP_ANDNC:   begin stb.carryUpd = 1'b1; stb.carryFn = CF_AND; stb.invertBit = 1'b1; end
      OP_XORC:    begin stb.carryUpd = 1'b1; stb.carryFn = CF_XOR; end
      OP_XORNC:   begin stb.carryUpd = 1'b1; stb.carryFn = CF_XOR; stb.invertBit = 1'b1; end
      OP_JSET:    begin stb.jump = 1'b1; stb.jumpOnSet = 1'b1; end
      OP_JCLR:    begin stb.jump = 1'b1; stb.jumpOnSet = 1'b0; end
      OP_JSETCLR: begin
        stb.jump       = 1'b1;
        stb.jumpOnSet  = 1'b1;
        stb.writeIfSet = 1'b1;
        stb.newBitSel  = NB_ZERO;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/boolbit_dp.sv
module boolbit_dp
  import boolbit_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CARRY_ADDR = 8'hD7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  strobes_t          stb,
  input  logic [BYTE_W-1:0] byteAddr,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              isCarry,
  input  logic [BYTE_W-1:0] rdData,
  output logic              wrEn,
  output logic [BYTE_W-1:0] wrAddr,
  output logic [BYTE_W-1:0] wrData,
  output logic              carry,
  output logic              jumpValid,
  output logic              jumpTaken
);
  localparam int CARRY_IDX = int'(CARRY_ADDR) % BYTE_W;

  logic              fwdHit;
  logic [BYTE_W-1:0] curByte;
  logic              bitVal;
  logic              operand;
  logic              newBit;
  logic              doWrite;
  logic [BYTE_W-1:0] newByte;
  logic              carryNext;
  logic [BYTE_W-1:0] oldByteQ;

  // Forward the registered write when the next read targets the same byte
  assign fwdHit  = wrEn && (wrAddr == byteAddr);
  assign curByte = fwdHit ? wrData : rdData;
  assign bitVal  = isCarry ? carry : curByte[bitIdx];
  assign operand = bitVal ^ stb.invertBit;

  always_comb begin
    unique case (stb.newBitSel)
      NB_ONE:   newBit = 1'b1;
      NB_ZERO:  newBit = 1'b0;
      NB_INV:   newBit = ~bitVal;
      NB_CARRY: newBit = carry;
      default:  newBit = 1'b0;
    endcase
  end

  assign doWrite = opValid && (stb.writeBit || (stb.writeIfSet && bitVal));

  always_comb begin
    newByte         = curByte;
    newByte[bitIdx] = newBit;
  end

  always_comb begin
    carryNext = carry;
    if (opValid) begin
      if (isCarry && doWrite) begin
        carryNext = newBit;
      end else if (stb.carryUpd) begin
        unique case (stb.carryFn)
          CF_LOAD: carryNext = operand;
          CF_OR:   carryNext = carry | operand;
          CF_AND:  carryNext = carry & operand;
          CF_XOR:  carryNext = carry ^ operand;
          default: carryNext = carry;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrEn      <= 1'b0;
      wrAddr    <= '0;
      wrData    <= '0;
      oldByteQ  <= '0;
      carry     <= 1'b0;
      jumpValid <= 1'b0;
      jumpTaken <= 1'b0;
    end else begin
      wrEn      <= doWrite;
      carry     <= carryNext;
      jumpValid <= opValid && stb.jump;
      jumpTaken <= opValid && stb.jump && (bitVal == stb.jumpOnSet);
      if (doWrite) begin
        wrAddr   <= byteAddr;
        wrData   <= newByte;
        oldByteQ <= curByte;
      end
    end
  end

  // R3: a write changes at most one bit of the byte it read
  p_single_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |-> ($countones(wrData ^ oldByteQ) <= 1));

  // R6: plain bit tests never write
  p_test_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && stb.jump && !stb.writeIfSet) |=> !wrEn);

  // R7: the test-and-clear form writes exactly when it jumps
  p_jbc_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && stb.writeIfSet) |=> (wrEn == jumpTaken) && jumpValid);

  // R8: writing the carry bit keeps the flag and the status byte in step
  p_carry_alias_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && isCarry && doWrite) |=> (carry == wrData[CARRY_IDX]));

  // R10: an idle cycle has no effect
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !opValid |=> (!wrEn && !jumpValid && $stable(carry)));
endmodule

// File: rtl/boolbit_unit.sv
module boolbit_unit
  import boolbit_pkg::*;
#(
  parameter logic [7:0] RAM_BASE   = 8'h20,
  parameter logic [7:0] CARRY_ADDR = 8'hD7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       opValid,
  input  logic [3:0] opCode,
  input  logic [7:0] bitAddr,
  output logic [7:0] rdAddr,
  input  logic [7:0] rdData,
  output logic       wrEn,
  output logic [7:0] wrAddr,
  output logic [7:0] wrData,
  output logic       carry,
  output logic       jumpValid,
  output logic       jumpTaken
);
  strobes_t          stb;
  logic [IDX_W-1:0]  bitIdx;
  logic              isCarry;

  boolbit_addrmap #(.RAM_BASE(RAM_BASE), .CARRY_ADDR(CARRY_ADDR)) map_i (
    .bitAddr (bitAddr),
    .byteAddr(rdAddr),
    .bitIdx  (bitIdx),
    .isCarry (isCarry)
  );

  boolbit_ctrl ctrl_i (
    .opCode(opCode),
    .stb   (stb)
  );

  boolbit_dp #(.CARRY_ADDR(CARRY_ADDR)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .opValid  (opValid),
    .stb      (stb),
    .byteAddr (rdAddr),
    .bitIdx   (bitIdx),
    .isCarry  (isCarry),
    .rdData   (rdData),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .carry    (carry),
    .jumpValid(jumpValid),
    .jumpTaken(jumpTaken)
  );

  // R1: low bit addresses land in the sixteen-byte RAM window
  p_low_map_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && !bitAddr[7]) |-> (rdAddr >= RAM_BASE) && (rdAddr < RAM_BASE + 8'd16));

  // R2: high bit addresses land on register bytes that are multiples of 8
  p_high_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && bitAddr[7]) |-> (rdAddr[2:0] == 3'b000) && rdAddr[7]);
endmodule

// File: tb/boolbit_unit_tb.sv
module boolbit_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       opValid = 1'b0;
  logic [3:0] opCode = 4'd0;
  logic [7:0] bitAddr = 8'd0;
  logic [7:0] rdAddr;
  logic [7:0] rdData;
  logic       wrEn;
  logic [7:0] wrAddr;
  logic [7:0] wrData;
  logic       carry;
  logic       jumpValid;
  logic       jumpTaken;

  always #2.5 clk = ~clk;

  boolbit_unit dut_i (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .bitAddr(bitAddr), .rdAddr(rdAddr), .rdData(rdData), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .carry(carry),
    .jumpValid(jumpValid), .jumpTaken(jumpTaken)
  );

  logic [7:0] mem [256];
  logic [7:0] refMem [256];
  logic       expC = 1'b0;
  int         errors = 0;
  int         checks = 0;
  int         cyc = 0;
  int         lastWrByte = -1;

  assign rdData = mem[rdAddr];

  always @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d exp<150000", cyc);
      finishRun();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int mapByte(input int a);
    if (a < 128) return 32 + a / 8;
    return a - (a % 8);
  endfunction

  task automatic doOp(input int o, input int a);
    int     b;
    int     idx;
    logic   bv;
    logic   nb;
    logic   wr;
    logic   jv;
    logic   jt;
    logic   c0;
    logic [7:0] nbyte;
    string  tag;
    b   = mapByte(a);
    idx = a % 8;
    c0  = expC;
    bv  = (a == 215) ? expC : refMem[b][idx];
    nb  = 1'b0; wr = 1'b0; jv = 1'b0; jt = 1'b0;
    case (o)
      1:  begin wr = 1'b1; nb = 1'b1; tag = "R3"; end
      2:  begin wr = 1'b1; nb = 1'b0; tag = "R3"; end
      3:  begin wr = 1'b1; nb = ~bv;  tag = "R3"; end
      4:  begin expC = bv;            tag = "R4"; end
      5:  begin wr = 1'b1; nb = c0;   tag = "R4"; end
      6:  begin expC = c0 | bv;       tag = "R5"; end
      7:  begin expC = c0 | ~bv;      tag = "R5"; end
      8:  begin expC = c0 & bv;       tag = "R5"; end
      9:  begin expC = c0 & ~bv;      tag = "R5"; end
      10: begin expC = c0 ^ bv;       tag = "R5"; end
      11: begin expC = c0 ^ ~bv;      tag = "R5"; end
      12: begin jv = 1'b1; jt = bv;   tag = "R6"; end
      13: begin jv = 1'b1; jt = ~bv;  tag = "R6"; end
      14: begin jv = 1'b1; jt = bv; wr = bv; nb = 1'b0; tag = "R7"; end
      default: tag = "R10";
    endcase
    if (a == 215) tag = {tag, "/R8"};
    if (lastWrByte == b) tag = {tag, "/R9"};
    nbyte = refMem[b];
    if (wr) begin
      nbyte[idx] = nb;
      refMem[b]  = nbyte;
      if (a == 215) expC = nb;
    end
    lastWrByte = wr ? b : -1;

    opValid = 1'b1;
    opCode  = 4'(o);
    bitAddr = 8'(a);
    #1;
    chk((a < 128) ? "R1 rdAddr" : "R2 rdAddr", 32'(rdAddr), 32'(b));
    @(negedge clk);
    chk({tag, " wrEn"}, 32'(wrEn), 32'(wr));
    if (wr) begin
      chk({tag, " wrAddr"}, 32'(wrAddr), 32'(b));
      chk({tag, " wrData"}, 32'(wrData), 32'(nbyte));
    end
    chk({tag, " carry"}, 32'(carry), 32'(expC));
    chk({tag, " jumpValid"}, 32'(jumpValid), 32'(jv));
    if (jv) chk({tag, " jumpTaken"}, 32'(jumpTaken), 32'(jt));
  endtask

  task automatic idleCycle(input int o, input logic valid);
    opValid = valid;
    opCode  = 4'(o);
    bitAddr = 8'(o * 17);
    lastWrByte = -1;
    @(negedge clk);
    chk("R10 idle wrEn", 32'(wrEn), 32'd0);
    chk("R10 idle jumpValid", 32'(jumpValid), 32'd0);
    chk("R10 idle carry", 32'(carry), 32'(expC));
  endtask

  initial begin
    logic [7:0] lfsr;
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 8'((i * 37 + 5) ^ (i >> 2));
      refMem[i] = 8'((i * 37 + 5) ^ (i >> 2));
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset wrEn", 32'(wrEn), 32'd0);
    chk("R10 reset carry", 32'(carry), 32'd0);
    chk("R10 reset jumpValid", 32'(jumpValid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 0; a < 256; a++) begin
      for (int o = 1; o <= 14; o++) doOp(o, a);
      idleCycle(a % 16, 1'b0);
      if (a % 32 == 0) begin
        idleCycle(0, 1'b1);
        idleCycle(15, 1'b1);
      end
    end

    lfsr = 8'hA5;
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      doOp(1 + (k * 5 + int'(lfsr)) % 14, (k % 7 == 0) ? 215 : int'(lfsr));
    end
    idleCycle(3, 1'b0);

    opValid = 1'b0;
    finishRun();
  end
endmodule